// File: doc/BRIEF.md
# Request-Response Delay Inheritance Table

This block sits at the network interface of a shared cache slice. It carries the interference delay of one request over to the response that the request causes. When a request packet arrives, its request ID, miss-handler ID and accumulated interference delay go into a free table entry. When the cache later produces the matching response, the block looks up that entry by both IDs and hands the stored delay to the response as its starting value. The entry is freed in the same cycle.

The cache access itself is not modelled. It is seen only as a lookup handshake carrying the two IDs. When the response later reaches its requester, a separate accumulate port adds the delay the response gathered on its own trip to the value it carried. The result is the interference total of the whole transaction, held in 8 bits and saturating.

Top module: `dit_table`

## Requirements
- R1: After synchronous reset the table is empty. `req_ready` is 1, `req_slot` is 0 and `tot_valid` is 0.
- R2: A request is taken when `req_valid` and `req_ready` are both 1. It is written into the lowest-numbered free entry, and `req_slot` shows that entry index in the cycle it is taken.
- R3: In a cycle with `gen_valid` = 1, a live entry whose request ID equals `gen_rid` and whose miss-handler ID equals `gen_mid` is a hit. A hit drives `gen_dly` with that entry's stored delay and drives `gen_miss` to 0 in the same cycle.
- R4: A lookup that matches no live entry is a miss. This includes a key where only one of the two IDs matches. A miss drives `gen_dly` to 0 and `gen_miss` to 1, and it leaves every entry unchanged.
- R5: A hit frees its entry at the same clock edge. A repeat lookup of that key then misses, and the freed index can be allocated again.
- R6: While all 16 entries are live, `req_ready` is 0 and a request presented with `req_valid` = 1 is ignored.
- R7: In the cycle after a hit frees an entry of a full table, `req_ready` is 1 again.
- R8: When `arr_valid` is 1, one cycle later `tot_valid` is 1 and `tot_dly` equals `arr_carried + arr_leg` (for example 5 + 3 gives 8). When `arr_valid` is 0, one cycle later `tot_valid` is 0.
- R9: The sum in R8 saturates at 255 and never wraps.
- R10: While `gen_valid` is 0, `gen_miss` and `gen_dly` are both 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request packet arrival |
| req_ready | output | 1 | A free entry exists |
| req_rid | input | 6 | Request ID of arriving request |
| req_mid | input | 4 | Miss-handler ID of arriving request |
| req_dly | input | 8 | Interference delay gathered by the request packet |
| req_slot | output | 4 | Entry index a request taken this cycle goes to |
| gen_valid | input | 1 | Cache is generating a response this cycle |
| gen_rid | input | 6 | Request ID of the response |
| gen_mid | input | 4 | Miss-handler ID of the response |
| gen_dly | output | 8 | Starting delay for the response |
| gen_miss | output | 1 | No matching entry for the response |
| arr_valid | input | 1 | Response arrives at its requester |
| arr_carried | input | 8 | Delay the response inherited |
| arr_leg | input | 8 | Delay the response gathered in the network |
| tot_valid | output | 1 | Total delay is valid |
| tot_dly | output | 8 | Saturated total interference delay |

## Verification
The assertions assume that the pair of request ID and miss-handler ID is unique among live entries. A key is never stored twice, so at most one entry can match a lookup. The stimulus keeps to this: every stored key uses distinct request IDs, and a key is reused only after its entry has been freed. Lookups and requests are never driven in the same cycle, so each check sees the table as it was after the previous edge. The accumulate path is swept over a grid of operand pairs that covers both sides of the 255 saturation point.

// File: rtl/dit_pkg.sv
package dit_pkg;
    localparam int RID_W     = 6;
    localparam int MID_W     = 4;
    localparam int DLY_W     = 8;
    localparam int TBL_DEPTH = 16;

    typedef logic [RID_W-1:0] rid_t;
    typedef logic [MID_W-1:0] mid_t;
    typedef logic [DLY_W-1:0] dly_t;

    localparam dly_t DLY_MAX = '1;

    typedef struct packed {
        rid_t rid;
        mid_t mid;
    } key_t;

    typedef struct packed {
        logic live;
        key_t key;
        dly_t dly;
    } ent_t;

    function automatic dly_t sat_add(dly_t a, dly_t b);
        logic [DLY_W:0] s;
        s = {1'b0, a} + {1'b0, b};
        return s[DLY_W] ? DLY_MAX : s[DLY_W-1:0];
    endfunction
endpackage

// File: rtl/dit_lowfree.sv
module dit_lowfree #(
    parameter int N  = 16,
    parameter int IW = $clog2(N)
) (
    input  logic [N-1:0]  live,
    output logic          any_free,
    output logic [IW-1:0] idx
);
    always_comb begin
        any_free = 1'b0;
        idx      = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (!live[i]) begin
                any_free = 1'b1;
                idx      = IW'(i);
            end
        end
    end
endmodule

// File: rtl/dit_keymatch.sv
module dit_keymatch
    import dit_pkg::*;
#(
    parameter int N  = 16,
    parameter int IW = $clog2(N)
) (
    input  logic            clk,
    input  logic            rst,
    input  ent_t [N-1:0]    ents,
    input  logic            en,
    input  key_t            key,
    output logic            hit,
    output logic [IW-1:0]   idx,
    output dly_t            dly
);
    logic [N-1:0] hit_vec;

    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign hit_vec[g] = en && ents[g].live && (ents[g].key == key);
    end

    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (hit_vec[i]) idx = IW'(i);
        end
    end

    assign hit = |hit_vec;
    assign dly = hit ? ents[idx].dly : '0;

    // R3
    unique_key_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(hit_vec));
endmodule

// File: rtl/dit_satacc.sv
module dit_satacc
    import dit_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic in_valid,
    input  dly_t carried,
    input  dly_t leg,
    output logic out_valid,
    output dly_t out_dly
);
    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_dly   <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) out_dly <= sat_add(carried, leg);
        end
    end

    // R8
    tot_follow_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    // R9
    no_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> (out_dly >= $past(carried) && out_dly >= $past(leg)));
endmodule

// File: rtl/dit_table.sv
module dit_table
    import dit_pkg::*;
#(
    parameter int DEPTH = TBL_DEPTH,
    localparam int IW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [RID_W-1:0] req_rid,
    input  logic [MID_W-1:0] req_mid,
    input  logic [DLY_W-1:0] req_dly,
    output logic [IW-1:0]    req_slot,
    input  logic             gen_valid,
    input  logic [RID_W-1:0] gen_rid,
    input  logic [MID_W-1:0] gen_mid,
    output logic [DLY_W-1:0] gen_dly,
    output logic             gen_miss,
    input  logic             arr_valid,
    input  logic [DLY_W-1:0] arr_carried,
    input  logic [DLY_W-1:0] arr_leg,
    output logic             tot_valid,
    output logic [DLY_W-1:0] tot_dly
);
    ent_t [DEPTH-1:0] tbl_q;
    logic [DEPTH-1:0] live;
    logic             req_fire;
    logic             gen_hit;
    logic [IW-1:0]    hit_idx;
    key_t             gen_key;

    always_comb begin
        for (int i = 0; i < DEPTH; i++) live[i] = tbl_q[i].live;
    end

    dit_lowfree #(.N(DEPTH), .IW(IW)) u_free (
        .live     (live),
        .any_free (req_ready),
        .idx      (req_slot)
    );

    assign gen_key = '{rid: gen_rid, mid: gen_mid};

    dit_keymatch #(.N(DEPTH), .IW(IW)) u_match (
        .clk  (clk),
        .rst  (rst),
        .ents (tbl_q),
        .en   (gen_valid),
        .key  (gen_key),
        .hit  (gen_hit),
        .idx  (hit_idx),
        .dly  (gen_dly)
    );

    assign gen_miss = gen_valid && !gen_hit;
    assign req_fire = req_valid && req_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            tbl_q <= '0;
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                if (req_fire && req_slot == IW'(i)) begin
                    tbl_q[i] <= '{live: 1'b1,
                                  key:  '{rid: req_rid, mid: req_mid},
                                  dly:  req_dly};
                end else if (gen_hit && hit_idx == IW'(i)) begin
                    tbl_q[i].live <= 1'b0;
                end
            end
        end
    end

    dit_satacc u_acc (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (arr_valid),
        .carried   (arr_carried),
        .leg       (arr_leg),
        .out_valid (tot_valid),
        .out_dly   (tot_dly)
    );

    // R2
    alloc_live_chk: assert property (@(posedge clk) disable iff (rst)
        req_fire |=> tbl_q[$past(req_slot)].live);

    // R5
    free_on_hit_chk: assert property (@(posedge clk) disable iff (rst)
        gen_hit |=> !tbl_q[$past(hit_idx)].live);

    // R6
    stay_full_chk: assert property (@(posedge clk) disable iff (rst)
        (!req_ready && !gen_hit) |=> !req_ready);

    // R7
    reopen_chk: assert property (@(posedge clk) disable iff (rst)
        (!req_ready && gen_hit) |=> req_ready);

    // R10
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !gen_valid |-> (!gen_miss && gen_dly == '0));
endmodule

// File: tb/sim_dit_table.sv
module sim_dit_table;
    localparam int PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       req_valid = 1'b0;
    logic       req_ready;
    logic [5:0] req_rid = '0;
    logic [3:0] req_mid = '0;
    logic [7:0] req_dly = '0;
    logic [3:0] req_slot;
    logic       gen_valid = 1'b0;
    logic [5:0] gen_rid = '0;
    logic [3:0] gen_mid = '0;
    logic [7:0] gen_dly;
    logic       gen_miss;
    logic       arr_valid = 1'b0;
    logic [7:0] arr_carried = '0;
    logic [7:0] arr_leg = '0;
    logic       tot_valid;
    logic [7:0] tot_dly;

    int checks = 0;
    int errors = 0;

    always #(PERIOD/2) clk = ~clk;

    dit_table u0 (.*);

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int krid(int i);
        return i * 3 + 1;
    endfunction

    function automatic int kdly(int i);
        return i * 13 + 5;
    endfunction

    task automatic lookup(int rid, int mid, string req, int exp_miss, int exp_dly);
        @(negedge clk);
        gen_valid = 1'b1; gen_rid = 6'(rid); gen_mid = 4'(mid);
        #1;
        chk({req, " miss"}, int'(gen_miss), exp_miss);
        chk({req, " dly"}, int'(gen_dly), exp_dly);
        @(posedge clk);
        @(negedge clk);
        gen_valid = 1'b0;
    endtask

    initial begin
        #(PERIOD * 100000);
        errors++; checks++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        chk("R1 ready", int'(req_ready), 1);
        chk("R1 slot", int'(req_slot), 0);
        chk("R1 tot_valid", int'(tot_valid), 0);
        chk("R10 idle miss", int'(gen_miss), 0);
        chk("R10 idle dly", int'(gen_dly), 0);

        for (int i = 0; i < 16; i++) begin
            @(negedge clk);
            req_valid = 1'b1; req_rid = 6'(krid(i)); req_mid = 4'(i); req_dly = 8'(kdly(i));
            #1;
            chk("R2 slot", int'(req_slot), i);
            chk("R6 ready before full", int'(req_ready), 1);
            @(posedge clk);
        end
        @(negedge clk);
        req_valid = 1'b1; req_rid = 6'd63; req_mid = 4'd15; req_dly = 8'd99;
        #1;
        chk("R6 ready full", int'(req_ready), 0);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        lookup(63, 15, "R6 ignored request", 1, 0);

        lookup(krid(3), 4, "R4 mid mismatch", 1, 0);
        lookup(krid(4), 3, "R4 rid mismatch", 1, 0);

        lookup(krid(5), 5, "R3 hit", 0, kdly(5));
        #1;
        chk("R7 ready after free", int'(req_ready), 1);
        chk("R5 freed slot", int'(req_slot), 5);
        lookup(krid(5), 5, "R5 repeat", 1, 0);

        @(negedge clk);
        req_valid = 1'b1; req_rid = 6'd50; req_mid = 4'd9; req_dly = 8'd200;
        #1;
        chk("R5 reuse slot", int'(req_slot), 5);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        #1;
        chk("R6 full again", int'(req_ready), 0);

        for (int i = 15; i >= 0; i--) begin
            if (i != 5) lookup(krid(i), i, "R3 drain", 0, kdly(i));
        end
        lookup(50, 9, "R3 reused entry", 0, 200);
        #1;
        chk("R4 empty ready", int'(req_ready), 1);
        chk("R2 lowest after drain", int'(req_slot), 0);

        // R8 example 5 + 3
        @(negedge clk);
        arr_valid = 1'b1; arr_carried = 8'd5; arr_leg = 8'd3;
        @(posedge clk); #1;
        chk("R8 valid", int'(tot_valid), 1);
        chk("R8 five plus three", int'(tot_dly), 8);
        for (int a = 0; a < 256; a += 15) begin
            for (int b = 0; b < 256; b += 17) begin
                @(negedge clk);
                arr_carried = 8'(a); arr_leg = 8'(b);
                @(posedge clk); #1;
                chk("R9 sweep", int'(tot_dly), (a + b > 255) ? 255 : a + b);
            end
        end
        @(negedge clk);
        arr_carried = 8'd128; arr_leg = 8'd127;
        @(posedge clk); #1;
        chk("R9 edge 255", int'(tot_dly), 255);
        @(negedge clk);
        arr_carried = 8'd128; arr_leg = 8'd128;
        @(posedge clk); #1;
        chk("R9 over", int'(tot_dly), 255);
        @(negedge clk);
        arr_valid = 1'b0;
        @(posedge clk); #1;
        chk("R8 idle", int'(tot_valid), 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule